// File: doc/BRIEF.md
# Modem Control and Status with Loopback

This block owns the modem-control byte of a serial port and builds the matching modem-status byte. Two control bits drive the active-low data-terminal-ready and request-to-send outputs. Another control bit enables the interrupt output driver. A further bit selects local loopback. The four active-low modem inputs (clear-to-send, data-set-ready, ring, carrier) pass through a synchroniser before use. The status byte shows their active-high levels in the upper nibble and change-detect flags in the lower nibble. A status read clears the change flags. Any pending flag raises a modem-status interrupt request, which goes to an interrupt priority encoder outside this block.

In loopback the external modem inputs play no part. The four status levels are taken from the low control bits instead, and the modem outputs rest at their inactive level. The block gives the loopback select to the data path, which holds the serial output at mark and feeds it back to the receiver. Bus decoding and the UART data paths are not part of this block.

Top module: `modem_ctrl_stat`

## Requirements
- R1: After reset the control byte reads 0x00 and the status byte reads 0x00. Both dtr_no and rts_no are high, and loop_o, irq_oe_o and msi_req_o are low.
- R2: A write stores bits 4:0 of the data. Control bits 7:5 always read as zero.
- R3: Outside loopback, dtr_no equals the inverse of control bit 0 and rts_no equals the inverse of control bit 1. In loopback both are held high.
- R4: loop_o equals control bit 4, and irq_oe_o equals control bit 3.
- R5: Outside loopback, status bits 7:4 hold the inverted synchronised values of cd_ni, ri_ni, dsr_ni and cts_ni, in that bit order (bit 7 carrier). An input change shows after two clock edges.
- R6: In loopback, status bit 4 follows control bit 1, bit 5 follows control bit 0, bit 6 follows control bit 2 and bit 7 follows control bit 3. The external modem inputs have no effect.
- R7: Status bits 0, 1 and 3 are set one edge after status bit 4, 5 or 7 respectively changes value in either direction.
- R8: Status bit 2 is set only when status bit 6 falls from 1 to 0 (ring input released). A rise of bit 6 does not set it.
- R9: Asserting stat_re_i for one cycle clears all four change bits at the next edge. A change detected in that same cycle still sets its bit.
- R10: msi_req_o is high exactly when any of status bits 3:0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control byte write strobe |
| ctl_wdata_i | input | 8 | Control byte write data |
| stat_re_i | input | 1 | Status read strobe, clears change bits |
| ctl_rdata_o | output | 8 | Control byte read value |
| stat_rdata_o | output | 8 | Status byte read value |
| cts_ni | input | 1 | Clear-to-send, active low |
| dsr_ni | input | 1 | Data-set-ready, active low |
| ri_ni | input | 1 | Ring indicator, active low |
| cd_ni | input | 1 | Carrier detect, active low |
| dtr_no | output | 1 | Data-terminal-ready, active low |
| rts_no | output | 1 | Request-to-send, active low |
| loop_o | output | 1 | Loopback select for the data path |
| irq_oe_o | output | 1 | Interrupt output driver enable |
| msi_req_o | output | 1 | Modem-status interrupt request |

## Verification
The assertions assume that stat_re_i and ctl_we_i are single-cycle strobes from a synchronous bus. They also assume the modem inputs may change at any time, because the synchroniser absorbs that. The change-bit properties rely on the synchronised level being the only source of change. For that reason the bench changes modem inputs and control bits only at falling clock edges, and it holds each input level for several cycles. The read-with-change case is built on purpose so that the read strobe lands in the exact cycle in which a synchronised level moves.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int unsigned NLINES = 4;
  localparam int unsigned L_CTS  = 0;
  localparam int unsigned L_DSR  = 1;
  localparam int unsigned L_RI   = 2;
  localparam int unsigned L_CD   = 3;

  typedef logic [NLINES-1:0] lines_t;

  typedef struct packed {
    logic [2:0] rsvd;
    logic       loop;
    logic       irq_en;
    logic       aux;
    logic       rts;
    logic       dtr;
  } ctl_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    logic [WIDTH-1:0] src;
    if (s == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = stg[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= {WIDTH{RST_VAL}};
      else         stg[s] <= src;
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta #(
  parameter int unsigned     WIDTH     = 4,
  parameter logic [WIDTH-1:0] FALL_ONLY = 4'b0100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] delta_o
);
  logic [WIDTH-1:0] lvl_q, delta_q, chg;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (FALL_ONLY[i]) begin : g_fall
      assign chg[i] = lvl_q[i] & ~lvl_i[i];

      assert_ri_dir_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(delta_q[i]) |-> ($past(lvl_i[i], 2) && !$past(lvl_i[i])));
    end else begin : g_any
      assign chg[i] = lvl_q[i] ^ lvl_i[i];

      assert_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lvl_i[i] != $past(lvl_i[i])) |=> delta_q[i]);
    end

    assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (delta_q[i] && !clr_i) |=> delta_q[i]);
  end

  // change in the read cycle wins over the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q   <= '0;
      delta_q <= '0;
    end else begin
      lvl_q   <= lvl_i;
      delta_q <= (delta_q & ~{WIDTH{clr_i}}) | chg;
    end
  end

  assign delta_o = delta_q;
endmodule

// File: rtl/modem_ctrl_stat.sv
module modem_ctrl_stat
  import mdm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctl_we_i,
  input  logic [7:0] ctl_wdata_i,
  input  logic       stat_re_i,
  output logic [7:0] ctl_rdata_o,
  output logic [7:0] stat_rdata_o,
  input  logic       cts_ni,
  input  logic       dsr_ni,
  input  logic       ri_ni,
  input  logic       cd_ni,
  output logic       dtr_no,
  output logic       rts_no,
  output logic       loop_o,
  output logic       irq_oe_o,
  output logic       msi_req_o
);
  localparam logic [NLINES-1:0] RI_MASK = lines_t'(1) << L_RI;

  ctl_t   ctl_q;
  lines_t ext_sync, loop_lvl, lvl, delta;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctl_q <= '0;
    else if (ctl_we_i) ctl_q <= ctl_t'({3'b000, ctl_wdata_i[4:0]});
  end

  mdm_sync #(
    .WIDTH  (NLINES),
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cd_ni, ri_ni, dsr_ni, cts_ni}),
    .q_o   (ext_sync)
  );

  always_comb begin
    loop_lvl        = '0;
    loop_lvl[L_CTS] = ctl_q.rts;
    loop_lvl[L_DSR] = ctl_q.dtr;
    loop_lvl[L_RI]  = ctl_q.aux;
    loop_lvl[L_CD]  = ctl_q.irq_en;
  end

  assign lvl = ctl_q.loop ? loop_lvl : ~ext_sync;

  mdm_delta #(
    .WIDTH    (NLINES),
    .FALL_ONLY(RI_MASK)
  ) u_delta (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl),
    .clr_i  (stat_re_i),
    .delta_o(delta)
  );

  assign ctl_rdata_o  = ctl_q;
  assign stat_rdata_o = {lvl, delta};
  assign dtr_no       = ctl_q.loop | ~ctl_q.dtr;
  assign rts_no       = ctl_q.loop | ~ctl_q.rts;
  assign loop_o       = ctl_q.loop;
  assign irq_oe_o     = ctl_q.irq_en;
  assign msi_req_o    = |delta;

  assert_loop_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_o |-> (dtr_no && rts_no));

  assert_rd_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_re_i && $stable(stat_rdata_o[7:4])) |=> (stat_rdata_o[3:0] == 4'h0));

  assert_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msi_req_o) |-> (stat_rdata_o[3:0] != 4'h0));
endmodule

// File: tb/modem_ctrl_stat_tb.sv
module modem_ctrl_stat_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic       stat_re = 1'b0;
  logic [7:0] ctl_rdata, stat_rdata;
  logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, cd_n = 1'b1;
  logic       dtr_n, rts_n, loop_s, irq_oe, msi_req;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  modem_ctrl_stat u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata), .stat_re_i(stat_re),
    .ctl_rdata_o(ctl_rdata), .stat_rdata_o(stat_rdata),
    .cts_ni(cts_n), .dsr_ni(dsr_n), .ri_ni(ri_n), .cd_ni(cd_n),
    .dtr_no(dtr_n), .rts_no(rts_n), .loop_o(loop_s),
    .irq_oe_o(irq_oe), .msi_req_o(msi_req)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: input history plus flags
  logic [7:0] m_ctl;
  logic [3:0] m_h1, m_h2, m_prev, m_delta, m_old, m_chg;

  function automatic logic [3:0] lvl_of(input logic [7:0] c, input logic [3:0] h);
    if (c[4]) return {c[3], c[2], c[0], c[1]};
    return ~h;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctl = '0; m_h1 = '1; m_h2 = '1; m_prev = '0; m_delta = '0;
    end else begin
      m_old = lvl_of(m_ctl, m_h2);
      for (int i = 0; i < 4; i++)
        m_chg[i] = (i == 2) ? (m_prev[i] && !m_old[i]) : (m_prev[i] != m_old[i]);
      m_delta = (stat_re ? 4'h0 : m_delta) | m_chg;
      m_prev  = m_old;
      m_h2    = m_h1;
      m_h1    = {cd_n, ri_n, dsr_n, cts_n};
      if (ctl_we) m_ctl = {3'b000, ctl_wdata[4:0]};
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 ctl", ctl_rdata, m_ctl);
      chk("R3 dtr", {7'd0, dtr_n}, {7'd0, m_ctl[4] | ~m_ctl[0]});
      chk("R3 rts", {7'd0, rts_n}, {7'd0, m_ctl[4] | ~m_ctl[1]});
      chk("R4 loop", {6'd0, loop_s, irq_oe}, {6'd0, m_ctl[4], m_ctl[3]});
      chk(m_ctl[4] ? "R6 level" : "R5 level", {4'd0, stat_rdata[7:4]}, {4'd0, lvl_of(m_ctl, m_h2)});
      chk("R7 delta", {4'd0, stat_rdata[3:0]}, {4'd0, m_delta});
      chk("R10 req", {7'd0, msi_req}, {7'd0, |m_delta});
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); stat_re = 1'b1;
    @(negedge clk); stat_re = 1'b0;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    waitn(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ctl", ctl_rdata, 8'h00);
    chk("R1 stat", stat_rdata, 8'h00);
    chk("R1 pins", {3'd0, dtr_n, rts_n, loop_s, irq_oe, msi_req}, 8'b0001_1000);

    wr(8'hE3);
    chk("R2 mask", ctl_rdata, 8'h03);
    chk("R3 low", {6'd0, dtr_n, rts_n}, 8'h00);
    wr(8'h08);
    chk("R4 oe", {6'd0, loop_s, irq_oe}, 8'h01);

    cts_n = 1'b0;
    waitn(2);
    chk("R5 latency", stat_rdata, 8'h10);
    waitn(1);
    chk("R7 cts fall", stat_rdata, 8'h11);
    chk("R10 set", {7'd0, msi_req}, 8'h01);
    rd();
    chk("R9 clear", stat_rdata, 8'h10);

    ri_n = 1'b0;
    waitn(3);
    chk("R8 ring on", stat_rdata, 8'h50);
    ri_n = 1'b1;
    waitn(3);
    chk("R8 ring off", stat_rdata, 8'h14);

    dsr_n = 1'b0;
    waitn(3);
    chk("R7 dsr", stat_rdata, 8'h36);
    cts_n = 1'b1;
    waitn(2);
    stat_re = 1'b1;
    @(negedge clk); stat_re = 1'b0;
    chk("R9 same cycle", stat_rdata, 8'h21);

    wr(8'h1F);
    chk("R6 loop lvl", {4'd0, stat_rdata[7:4]}, 8'h0F);
    chk("R3 loop pins", {6'd0, dtr_n, rts_n}, 8'h03);
    rd();
    cts_n = 1'b0; dsr_n = 1'b1; cd_n = 1'b0; ri_n = 1'b0;
    waitn(4);
    chk("R6 ignore", stat_rdata, 8'hF0);
    wr(8'h10);
    chk("R6 loop zero", stat_rdata, 8'h00);
    waitn(1);
    chk("R8 loop ring", stat_rdata, 8'h0F);
    rd();
    wr(8'h00);
    waitn(4);
    rd();
    waitn(2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule